// File: doc/BRIEF.md
# Four-Phase Multi-Mode PWM Generator

This block is a 12-bit pulse-width modulation engine that drives two complementary-style outputs, A and B. Each PWM cycle passes through four phases in a fixed order: dead time A, on time A, dead time B, on time B. Four compare values (A-set, A-clear, B-set, B-clear) shape the phases. A 2-bit mode input picks how those values are used: one ramp, two ramps, four ramps, or a dual-slope count that runs down and then up again.

The counter advances only on a clock-enable tick, which stands in for the prescaler that a surrounding subsystem would provide. The compare values, the mode and the override settings arrive as already-synchronized inputs. An optional override turns the fixed phase-to-output rule into a table with one bit per output per phase.

The block reports the end of every cycle with a one-clock pulse and a sticky flag. A second sticky flag records any change of output level. Each flag is cleared by a one-clock clear strobe. When a set and a clear arrive in the same clock, the set wins.

Top module: `pwm4_gen`

## Requirements
- R1: A synchronous active-high reset returns the block to the start of the first ramp in dead time A (phase code 0), with both outputs at the dead-time-A level and all flags and the overflow pulse at 0.
- R2: The internal position changes only in a clock where the tick is high; in a clock with the tick low, the reported phase holds its value.
- R3: The phase is reported with the codes dead time A = 0, on time A = 1, dead time B = 2 and on time B = 3. In one-ramp mode (mode 0) the count runs from 0 to B-clear, so a cycle lasts B-clear+1 ticks. At count c the phase is on time B if c > B-set, else dead time B if c > A-clear, else on time A if c > A-set, else dead time A. Values above B-clear never take effect, and out-of-order values skip phases.
- R4: In two-ramp mode (mode 1) a first ramp counts 0 to A-clear, with dead time A while c ≤ A-set and on time A after that. A second ramp counts 0 to B-clear, with dead time B while c ≤ B-set and on time B after that. A cycle lasts (A-clear+1)+(B-clear+1) ticks, so dead time A lasts at least one tick.
- R5: In four-ramp mode (mode 2) the four phases take A-set+1, A-clear+1, B-set+1 and B-clear+1 ticks in sequence, one ramp per compare value, and they never overlap.
- R6: In dual-slope mode (mode 3) the value runs from B-clear down to 0, then from 0 up to B-clear. A cycle lasts 2·(B-clear+1) ticks, and A-clear has no effect. A value ≤ A-set gives on time A. Otherwise a value > B-set gives on time B. Otherwise the phase is dead time A on the down slope and dead time B on the up slope. When both conditions hold, on time A takes precedence.
- R7: During the down slope of the first dual-slope cycle after reset, the on-time-B condition is suppressed, so output B stays low until the B-set crossing on the rising slope.
- R8: With the override off, output A is high only in on time A, output B is high only in on time B, and both are low in both dead times.
- R9: With the override on, output A takes bit p of the 8-bit override value and output B takes bit 4+p, where p is the phase code. An all-zero value therefore drives both outputs low in every phase.
- R10: The tick that completes a cycle produces a one-clock overflow pulse in the following clock and sets the sticky overflow flag. A clear strobe clears the flag, and a set in the same clock wins over the clear.
- R11: Any change of level on either output sets the sticky change flag one clock later. A clear strobe clears it, and a set in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable that advances the count |
| mode | input | 2 | 0 one ramp, 1 two ramp, 2 four ramp, 3 dual slope |
| cmp_a_set | input | 12 | A-set compare value |
| cmp_a_clr | input | 12 | A-clear compare value |
| cmp_b_set | input | 12 | B-set compare value |
| cmp_b_clr | input | 12 | B-clear compare value (top in one-ramp and dual-slope) |
| ovr_en | input | 1 | Use the override table for output levels |
| ovr_lvl | input | 8 | Override table: bits 3..0 for A, bits 7..4 for B, indexed by phase |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| chg_clr | input | 1 | Clear strobe for the change flag |
| out_a | output | 1 | Output A level |
| out_b | output | 1 | Output B level |
| phase | output | 2 | Current phase code |
| ovf_pulse | output | 1 | One-clock pulse after the cycle-completing tick |
| ovf_flag | output | 1 | Sticky cycle-end flag |
| chg_flag | output | 1 | Sticky output-change flag |

## Verification
Several rules are checked by assertions on every cycle:
- The position holds without a tick.
- Both outputs are low in dead times when the override is off.
- B stays low on the first dual-slope down slope.
- An overflow pulse only follows a tick and always comes with the overflow flag.
- An output change always raises the change flag in the next clock.

Only the bench scenarios can show that each mode produces the right phase at every position of the cycle, in the right order and for the right length, and that out-of-order or too-large compare values skip or drop phases. They also show that A-clear has no effect in dual slope, that the override table maps bits correctly, and that the set-wins-over-clear rule holds for both flags.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int PWM_CNT_W = 12;

    typedef enum logic [1:0] {
        PH_DTA = 2'd0,
        PH_OTA = 2'd1,
        PH_DTB = 2'd2,
        PH_OTB = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        MD_ONE  = 2'd0,
        MD_TWO  = 2'd1,
        MD_FOUR = 2'd2,
        MD_DUAL = 2'd3
    } mode_e;

    typedef struct packed {
        logic a;
        logic b;
    } lvl_t;

    // index of the final ramp of a cycle in each mode
    function automatic logic [1:0] last_ramp(mode_e m);
        case (m)
            MD_ONE:  return 2'd0;
            MD_FOUR: return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

    function automatic lvl_t plain_levels(phase_e p);
        lvl_t l;
        l.a = (p == PH_OTA);
        l.b = (p == PH_OTB);
        return l;
    endfunction

    function automatic lvl_t table_levels(phase_e p, logic [7:0] v);
        lvl_t l;
        l.a = v[3'(p)];
        l.b = v[3'd4 + 3'(p)];
        return l;
    endfunction

endpackage

// File: rtl/pwm4_ramp.sv
module pwm4_ramp
    import pwm4_pkg::*;
#(
    parameter int CNT_W = PWM_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  mode_e            mode,
    input  logic [CNT_W-1:0] aset,
    input  logic [CNT_W-1:0] aclr,
    input  logic [CNT_W-1:0] bset,
    input  logic [CNT_W-1:0] bclr,
    output logic [CNT_W-1:0] cnt,
    output logic [1:0]       ridx,
    output logic             first,
    output logic             cyc_end
);

    logic [CNT_W-1:0] lim;
    logic             ramp_end;
    logic             at_last;

    // end value of the ramp currently running
    always_comb begin
        case (mode)
            MD_TWO:  lim = (ridx == 2'd0) ? aclr : bclr;
            MD_FOUR: begin
                case (ridx)
                    2'd0:    lim = aset;
                    2'd1:    lim = aclr;
                    2'd2:    lim = bset;
                    default: lim = bclr;
                endcase
            end
            default: lim = bclr;
        endcase
    end

    // >= keeps the ramp bounded if a limit drops below the count
    assign ramp_end = (cnt >= lim);
    assign at_last  = (ridx >= last_ramp(mode));
    assign cyc_end  = tick && ramp_end && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            ridx  <= 2'd0;
            first <= 1'b1;
        end else if (tick) begin
            if (ramp_end) begin
                cnt   <= '0;
                first <= 1'b0;
                ridx  <= at_last ? 2'd0 : ridx + 2'd1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: position frozen while tick is low
    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(cnt) && $stable(ridx)));

endmodule

// File: rtl/pwm4_phase.sv
module pwm4_phase
    import pwm4_pkg::*;
#(
    parameter int CNT_W = PWM_CNT_W
) (
    input  mode_e            mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       ridx,
    input  logic             first,
    input  logic [CNT_W-1:0] aset,
    input  logic [CNT_W-1:0] aclr,
    input  logic [CNT_W-1:0] bset,
    input  logic [CNT_W-1:0] bclr,
    output phase_e           phase
);

    logic [CNT_W-1:0] ds_val;
    logic             ds_down;
    logic             ds_a_on;
    logic             ds_b_on;

    // dual slope: ramp 0 is mirrored into a falling value
    assign ds_down = (ridx == 2'd0);
    assign ds_val  = ds_down ? (bclr - cnt) : cnt;
    assign ds_a_on = (ds_val <= aset);
    assign ds_b_on = (ds_val > bset) && !(first && ds_down);

    always_comb begin
        case (mode)
            MD_ONE: begin
                if (cnt > bset)      phase = PH_OTB;
                else if (cnt > aclr) phase = PH_DTB;
                else if (cnt > aset) phase = PH_OTA;
                else                 phase = PH_DTA;
            end
            MD_TWO: begin
                if (ridx == 2'd0) phase = (cnt > aset) ? PH_OTA : PH_DTA;
                else              phase = (cnt > bset) ? PH_OTB : PH_DTB;
            end
            MD_FOUR: phase = phase_e'(ridx);
            default: begin
                if (ds_a_on)      phase = PH_OTA;
                else if (ds_b_on) phase = PH_OTB;
                else              phase = ds_down ? PH_DTA : PH_DTB;
            end
        endcase
    end

endmodule

// File: rtl/pwm4_out.sv
module pwm4_out
    import pwm4_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_e     phase,
    input  logic       ovr_en,
    input  logic [7:0] ovr_lvl,
    input  logic       chg_clr,
    output logic       out_a,
    output logic       out_b,
    output logic       chg_flag
);

    lvl_t lv;
    lvl_t lv_q;

    assign lv    = ovr_en ? table_levels(phase, ovr_lvl) : plain_levels(phase);
    assign out_a = lv.a;
    assign out_b = lv.b;

    // previous levels track the outputs at all times, reset included
    always_ff @(posedge clk) begin
        lv_q <= lv;
    end

    always_ff @(posedge clk) begin
        if (rst) chg_flag <= 1'b0;
        else     chg_flag <= (chg_flag && !chg_clr) || (lv != lv_q);
    end

    // R8: dead times keep both outputs low without override
    p_dead_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!ovr_en && (phase == PH_DTA || phase == PH_DTB)) |-> (!out_a && !out_b));

    // R11: a level change is always recorded
    p_change_seen_r11: assert property (@(posedge clk) disable iff (rst)
        ((out_a != $past(out_a)) || (out_b != $past(out_b))) |=> chg_flag);

endmodule

// File: rtl/pwm4_gen.sv
module pwm4_gen
    import pwm4_pkg::*;
#(
    parameter int CNT_W = PWM_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] cmp_a_set,
    input  logic [CNT_W-1:0] cmp_a_clr,
    input  logic [CNT_W-1:0] cmp_b_set,
    input  logic [CNT_W-1:0] cmp_b_clr,
    input  logic             ovr_en,
    input  logic [7:0]       ovr_lvl,
    input  logic             ovf_clr,
    input  logic             chg_clr,
    output logic             out_a,
    output logic             out_b,
    output logic [1:0]       phase,
    output logic             ovf_pulse,
    output logic             ovf_flag,
    output logic             chg_flag
);

    mode_e            md;
    phase_e           ph;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       ridx;
    logic             first;
    logic             cyc_end;

    assign md    = mode_e'(mode);
    assign phase = ph;

    pwm4_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (md),
        .aset    (cmp_a_set),
        .aclr    (cmp_a_clr),
        .bset    (cmp_b_set),
        .bclr    (cmp_b_clr),
        .cnt     (cnt),
        .ridx    (ridx),
        .first   (first),
        .cyc_end (cyc_end)
    );

    pwm4_phase #(.CNT_W(CNT_W)) u_phase (
        .mode  (md),
        .cnt   (cnt),
        .ridx  (ridx),
        .first (first),
        .aset  (cmp_a_set),
        .aclr  (cmp_a_clr),
        .bset  (cmp_b_set),
        .bclr  (cmp_b_clr),
        .phase (ph)
    );

    pwm4_out u_out (
        .clk      (clk),
        .rst      (rst),
        .phase    (ph),
        .ovr_en   (ovr_en),
        .ovr_lvl  (ovr_lvl),
        .chg_clr  (chg_clr),
        .out_a    (out_a),
        .out_b    (out_b),
        .chg_flag (chg_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_pulse <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            ovf_pulse <= cyc_end;
            ovf_flag  <= (ovf_flag && !ovf_clr) || cyc_end;
        end
    end

    // R10: a cycle end is only reached through a tick
    p_ovf_after_tick_r10: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> $past(tick));

    // R10: pulse and sticky flag appear together
    p_ovf_flag_r10: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> ovf_flag);

    // R7: B held low on the first falling slope
    p_first_b_low_r7: assert property (@(posedge clk) disable iff (rst)
        (md == MD_DUAL && first && ridx == 2'd0 && !ovr_en) |-> !out_b);

endmodule

// File: tb/pwm4_gen_tb.sv
module pwm4_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [11:0] cmp_a_set = '0;
    logic [11:0] cmp_a_clr = '0;
    logic [11:0] cmp_b_set = '0;
    logic [11:0] cmp_b_clr = '0;
    logic        ovr_en = 1'b0;
    logic [7:0]  ovr_lvl = '0;
    logic        ovf_clr = 1'b0;
    logic        chg_clr = 1'b0;
    logic        out_a, out_b, ovf_pulse, ovf_flag, chg_flag;
    logic [1:0]  phase;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    pwm4_gen u_dut (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode),
        .cmp_a_set(cmp_a_set), .cmp_a_clr(cmp_a_clr),
        .cmp_b_set(cmp_b_set), .cmp_b_clr(cmp_b_clr),
        .ovr_en(ovr_en), .ovr_lvl(ovr_lvl),
        .ovf_clr(ovf_clr), .chg_clr(chg_clr),
        .out_a(out_a), .out_b(out_b), .phase(phase),
        .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag), .chg_flag(chg_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cyc_len(int m, int a0, int a1, int b0, int b1);
        case (m)
            0:       return b1 + 1;
            1:       return a1 + b1 + 2;
            2:       return a0 + a1 + b0 + b1 + 4;
            default: return 2 * (b1 + 1);
        endcase
    endfunction

    // expected phase at tick position t of a cycle
    function automatic int exp_ph(int m, int t, bit fc, int a0, int a1, int b0, int b1);
        int v;
        bit down, a_on, b_on;
        case (m)
            0: begin
                if (t > b0) return 3;
                if (t > a1) return 2;
                if (t > a0) return 1;
                return 0;
            end
            1: begin
                if (t <= a1) return (t > a0) ? 1 : 0;
                return ((t - a1 - 1) > b0) ? 3 : 2;
            end
            2: begin
                if (t <= a0) return 0;
                if (t <= a0 + a1 + 1) return 1;
                if (t <= a0 + a1 + b0 + 2) return 2;
                return 3;
            end
            default: begin
                down = (t <= b1);
                v    = down ? (b1 - t) : (t - b1 - 1);
                a_on = (v <= a0);
                b_on = (v > b0) && !(fc && down);
                if (a_on) return 1;
                if (b_on) return 3;
                return down ? 0 : 2;
            end
        endcase
    endfunction

    function automatic int lvl_a(int ph, bit oe, logic [7:0] ov);
        return oe ? int'(ov[ph]) : int'(ph == 1);
    endfunction

    function automatic int lvl_b(int ph, bit oe, logic [7:0] ov);
        return oe ? int'(ov[ph + 4]) : int'(ph == 3);
    endfunction

    function automatic string mode_req(int m, bit fc, int t, int b1);
        if (m == 3 && fc && t <= b1) return "R7";
        case (m)
            0:       return "R3";
            1:       return "R4";
            2:       return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic step();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_scn(input int m, input int a0, input int a1, input int b0, input int b1,
                           input bit oe, input logic [7:0] ov, input int ncyc);
        int len, t, ph, held;
        bit fc;
        mode      = 2'(m);
        cmp_a_set = 12'(a0);
        cmp_a_clr = 12'(a1);
        cmp_b_set = 12'(b0);
        cmp_b_clr = 12'(b1);
        ovr_en    = oe;
        ovr_lvl   = ov;
        do_reset();
        chk("R1", "reset phase", phase, 0);
        chk("R1", "reset out_a", out_a, lvl_a(0, oe, ov));
        chk("R1", "reset out_b", out_b, lvl_b(0, oe, ov));
        chk("R1", "reset ovf_flag", ovf_flag, 0);
        chk("R1", "reset ovf_pulse", ovf_pulse, 0);
        chk("R1", "reset chg_flag", chg_flag, 0);
        len = cyc_len(m, a0, a1, b0, b1);
        for (int k = 0; k < len * ncyc; k++) begin
            t  = k % len;
            fc = (k < len);
            ph = exp_ph(m, t, fc, a0, a1, b0, b1);
            chk(mode_req(m, fc, t, b1), "phase", phase, ph);
            chk(oe ? "R9" : "R8", "out_a", out_a, lvl_a(ph, oe, ov));
            chk(oe ? "R9" : "R8", "out_b", out_b, lvl_b(ph, oe, ov));
            step();
            chk("R10", "ovf_pulse", ovf_pulse, int'(t == len - 1));
            held = phase;
            @(negedge clk);
            chk("R2", "phase held without tick", phase, held);
            chk("R10", "pulse one clock", ovf_pulse, 0);
        end
        chk("R10", "ovf_flag after cycles", ovf_flag, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // one ramp: ascending, out of order, values beyond the top
        run_scn(0, 2, 5, 7, 10, 1'b0, 8'h00, 2);
        run_scn(0, 6, 8, 3, 10, 1'b0, 8'h00, 2);
        run_scn(0, 12, 15, 14, 9, 1'b0, 8'h00, 1);
        // two ramp, including A-clear of zero
        run_scn(1, 1, 4, 2, 6, 1'b0, 8'h00, 2);
        run_scn(1, 0, 0, 3, 5, 1'b0, 8'h00, 2);
        // four ramp, including all-zero values
        run_scn(2, 1, 2, 0, 3, 1'b0, 8'h00, 2);
        run_scn(2, 0, 0, 0, 0, 1'b0, 8'h00, 3);
        // dual slope: A-clear changed must not matter, then overlapping conditions
        run_scn(3, 3, 9, 5, 8, 1'b0, 8'h00, 2);
        run_scn(3, 3, 0, 5, 8, 1'b0, 8'h00, 2);
        run_scn(3, 6, 1, 2, 8, 1'b0, 8'h00, 2);
        // override tables
        run_scn(0, 2, 5, 7, 10, 1'b1, 8'h5A, 1);
        run_scn(2, 1, 2, 0, 3, 1'b1, 8'hC3, 1);
        run_scn(3, 3, 9, 5, 8, 1'b1, 8'h96, 1);
        run_scn(1, 1, 4, 2, 6, 1'b1, 8'h00, 1);

        // flag clear behaviour, one ramp with cycle of 5 ticks
        mode = 2'd0; ovr_en = 1'b0;
        cmp_a_set = 12'd1; cmp_a_clr = 12'd2; cmp_b_set = 12'd3; cmp_b_clr = 12'd4;
        do_reset();
        for (int i = 0; i < 4; i++) step();
        chk("R10", "flag before end", ovf_flag, 0);
        tick = 1'b1; ovf_clr = 1'b1;
        @(negedge clk);
        tick = 1'b0; ovf_clr = 1'b0;
        chk("R10", "set wins over clear", ovf_flag, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R10", "flag cleared", ovf_flag, 0);
        @(negedge clk);
        chk("R10", "flag stays clear", ovf_flag, 0);

        chk("R11", "change flag after toggles", chg_flag, 1);
        chg_clr = 1'b1;
        @(negedge clk);
        chg_clr = 1'b0;
        chk("R11", "change flag cleared", chg_flag, 0);
        step();
        @(negedge clk);
        chk("R11", "no change no flag", chg_flag, 0);
        step();
        chk("R8", "out_a rises", out_a, 1);
        @(negedge clk);
        chk("R11", "rise sets flag", chg_flag, 1);
        chg_clr = 1'b1;
        step();
        chg_clr = 1'b0;
        @(negedge clk);
        chk("R11", "set wins over clear", chg_flag, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule